// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block carries out a single block-memory instruction: copy an element from a source index to a destination index, load an element into the accumulator, store the accumulator, scan memory against the accumulator, or compare two memory elements. A repeat prefix can wrap the instruction. It then loops under a count register until the count runs out or, for scan and compare, until the equality outcome ends the loop. The block owns the count, the two index registers and the accumulator. Each element access goes through a single memory port that waits on a ready handshake.

A repeated instruction can be broken off between elements by an interrupt request. Each finished element stays committed in the registers. The block reports how far the resume address must be moved back so that the whole prefixed instruction executes again. The index registers are stepped by a constant of 1 or of the word byte count. No ALU pass is used for this.

Top module: `strop_seq`

## Requirements
- R1: A move (op=0) reads the element at the source index, then writes it at the destination index in the extra segment (mem_seg=1). Without an override, the read uses the data segment (mem_seg=0). Words are stored low byte first at the lower address.
- R2: A scan (op=3) compares the accumulator with the element read at the destination index in the extra segment. A compare (op=4) compares the element read at the source index with the element read at the destination index. Either one sets zf to 1 on equality and to 0 otherwise. A byte compare looks only at bits 7:0.
- R3: Each access moves the index it used. The index goes up when dir=0 and down when dir=1.
- R4: The index step is 1 when wide=0 (byte) and 2 when wide=1 (16-bit word).
- R5: Under a repeat prefix (rep=1 while-equal, rep=2 while-not-equal), count drops by one per element, and the instruction completes when count reaches zero.
- R6: Load (op=1), store (op=2) and move run to count exhaustion under either repeat kind. Scan and compare also stop early: under rep=1 after an element that is not equal, and under rep=2 after an element that is equal.
- R7: A repeated byte load replaces acc[7:0] on every element, so acc ends holding the last element read. A word load replaces all 16 bits.
- R8: The block samples irq after each element of a repeated instruction. If irq is high and the instruction would otherwise continue, the block completes with intr=1 and the finished element's register updates kept. pc_back is then 2 if a segment override is present and 1 if not. pc_back and intr are 0 after a normal completion and hold until the next start.
- R9: A repeated instruction started with count 0 completes without any memory access and leaves all registers unchanged.
- R10: A non-repeated instruction (rep=0) performs exactly one element, ignores irq and leaves count unchanged.
- R11: A segment override (seg_ovr=1) makes source reads use the override segment (mem_seg=2). Destination accesses still use the extra segment.
- R12: When count exhaustion or an early stop falls on the same element as a pending irq, normal completion wins: intr=0 and pc_back=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| op | input | 3 | 0 move, 1 load, 2 store, 3 scan, 4 compare |
| wide | input | 1 | 0 byte, 1 word |
| rep | input | 2 | 0 none, 1 repeat while equal, 2 repeat while not equal |
| seg_ovr | input | 1 | Segment override prefix present |
| dir | input | 1 | 0 increment, 1 decrement |
| irq | input | 1 | Interrupt request |
| cnt_in | input | CW | Initial count |
| src_in | input | AW | Initial source index |
| dst_in | input | AW | Initial destination index |
| acc_in | input | DW | Initial accumulator |
| mem_req | output | 1 | Access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_seg | output | 2 | 0 data, 1 extra, 2 override |
| mem_addr | output | AW | Access offset |
| mem_wide | output | 1 | Access width, as wide |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ready | input | 1 | Access completes this cycle |
| done | output | 1 | One-cycle completion pulse |
| intr | output | 1 | Completion was due to interrupt |
| pc_back | output | 2 | Resume address backup amount |
| zf | output | 1 | Equality result of last scan/compare |
| cnt_out | output | CW | Count register |
| src_out | output | AW | Source index |
| dst_out | output | AW | Destination index |
| acc_out | output | DW | Accumulator |

## Verification
On the element where the loop would end anyway, either because count reaches zero or because a scan hits its stop condition, the block must settle two decisions in the same cycle: stop because the instruction is finished, and stop because irq is pending. The bench holds irq high through a repeated scan started with count 1. It then checks that the completion looks normal, with intr and pc_back both zero and count at zero. It also holds irq high through a longer move, with and without an override, to check that the interrupt path stops after exactly one element and reports a backup of 2 or 1.

// File: rtl/strop_pkg.sv
package strop_pkg;
  typedef enum logic [2:0] {OP_MOVE = 3'd0, OP_LOAD = 3'd1, OP_STORE = 3'd2,
                            OP_SCAN = 3'd3, OP_CMP = 3'd4} op_e;
  typedef enum logic [1:0] {REP_NONE = 2'd0, REP_EQ = 2'd1, REP_NE = 2'd2} rep_e;
  typedef enum logic [1:0] {SEG_DATA = 2'd0, SEG_EXTRA = 2'd1, SEG_OVR = 2'd2} seg_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CHECK, ST_RSRC, ST_RDST, ST_WDST, ST_STEP} st_e;
endpackage

// File: rtl/strop_idx_step.sv
// Constant-offset index adder: +/- 1 for bytes, +/- bytes-per-word for words.
module strop_idx_step #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic          wide,
  input  logic          dir,
  output logic [AW-1:0] nxt
);
  localparam int WB = DW / 8;
  logic [AW-1:0] stp;
  assign stp = wide ? AW'(WB) : AW'(1);
  assign nxt = dir ? (cur - stp) : (cur + stp);
endmodule

// File: rtl/strop_lane_cmp.sv
// Per-byte-lane equality; a byte operation looks at lane 0 only.
module strop_lane_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          wide,
  output logic          eq
);
  localparam int NL = DW / 8;
  logic [NL-1:0] lane;
  for (genvar i = 0; i < NL; i++) begin : g_lane
    assign lane[i] = (a[8*i +: 8] == b[8*i +: 8]);
  end
  assign eq = wide ? (&lane) : lane[0];
endmodule

// File: rtl/strop_term.sv
// End-of-element decision: finish outranks a pending interrupt.
module strop_term
  import strop_pkg::*;
(
  input  rep_e rep,
  input  logic is_cmp,
  input  logic cnt_last,
  input  logic eq,
  input  logic irq,
  output logic finish,
  output logic take_irq
);
  logic early;
  always_comb begin
    early = 1'b0;
    if (is_cmp) begin
      if (rep == REP_EQ) early = !eq;
      else if (rep == REP_NE) early = eq;
    end
    finish   = cnt_last || early;
    take_irq = !finish && irq;
  end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic          wide,
  input  logic [1:0]    rep,
  input  logic          seg_ovr,
  input  logic          dir,
  input  logic          irq,
  input  logic [CW-1:0] cnt_in,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [DW-1:0] acc_in,
  output logic          mem_req,
  output logic          mem_we,
  output logic [1:0]    mem_seg,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wide,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          done,
  output logic          intr,
  output logic [1:0]    pc_back,
  output logic          zf,
  output logic [CW-1:0] cnt_out,
  output logic [AW-1:0] src_out,
  output logic [AW-1:0] dst_out,
  output logic [DW-1:0] acc_out
);
  st_e           st_q;
  op_e           op_q;
  rep_e          rep_q;
  logic          wide_q, ovr_q, dir_q, eq_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_q, dst_q;
  logic [DW-1:0] acc_q, tmp_q;

  logic [AW-1:0] src_nx, dst_nx;
  logic          lane_eq, finish, take_irq;
  logic [DW-1:0] cmp_a;
  logic          busy_w, rep_none_w;

  assign busy_w     = (st_q != ST_IDLE);
  assign rep_none_w = (rep_q == REP_NONE);

  strop_idx_step #(.AW(AW), .DW(DW)) u_src_step (
    .cur(src_q), .wide(wide_q), .dir(dir_q), .nxt(src_nx));
  strop_idx_step #(.AW(AW), .DW(DW)) u_dst_step (
    .cur(dst_q), .wide(wide_q), .dir(dir_q), .nxt(dst_nx));

  assign cmp_a = (op_q == OP_SCAN) ? acc_q : tmp_q;
  strop_lane_cmp #(.DW(DW)) u_cmp (
    .a(cmp_a), .b(mem_rdata), .wide(wide_q), .eq(lane_eq));

  strop_term u_term (
    .rep(rep_q),
    .is_cmp((op_q == OP_SCAN) || (op_q == OP_CMP)),
    .cnt_last(cnt_q == CW'(1)),
    .eq(eq_q),
    .irq(irq),
    .finish(finish),
    .take_irq(take_irq));

  // Memory port: a pure function of registered state.
  always_comb begin
    mem_req   = (st_q == ST_RSRC) || (st_q == ST_RDST) || (st_q == ST_WDST);
    mem_we    = (st_q == ST_WDST);
    mem_addr  = (st_q == ST_RSRC) ? src_q : dst_q;
    mem_seg   = (st_q == ST_RSRC) ? (ovr_q ? SEG_OVR : SEG_DATA) : SEG_EXTRA;
    mem_wide  = wide_q;
    mem_wdata = (op_q == OP_MOVE) ? tmp_q : acc_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_MOVE;
      rep_q   <= REP_NONE;
      wide_q  <= 1'b0;
      ovr_q   <= 1'b0;
      dir_q   <= 1'b0;
      eq_q    <= 1'b0;
      cnt_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      acc_q   <= '0;
      tmp_q   <= '0;
      done    <= 1'b0;
      intr    <= 1'b0;
      pc_back <= 2'd0;
    end else begin
      done <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          op_q    <= op_e'(op);
          rep_q   <= rep_e'(rep);
          wide_q  <= wide;
          ovr_q   <= seg_ovr;
          dir_q   <= dir;
          cnt_q   <= cnt_in;
          src_q   <= src_in;
          dst_q   <= dst_in;
          acc_q   <= acc_in;
          intr    <= 1'b0;
          pc_back <= 2'd0;
          st_q    <= ST_CHECK;
        end
        ST_CHECK: begin
          if (rep_q != REP_NONE && cnt_q == '0) begin
            done <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            case (op_q)
              OP_STORE: st_q <= ST_WDST;
              OP_SCAN:  st_q <= ST_RDST;
              default:  st_q <= ST_RSRC;
            endcase
          end
        end
        ST_RSRC: if (mem_ready) begin
          src_q <= src_nx;
          tmp_q <= mem_rdata;
          case (op_q)
            OP_LOAD: begin
              acc_q <= wide_q ? mem_rdata : {acc_q[DW-1:8], mem_rdata[7:0]};
              st_q  <= ST_STEP;
            end
            OP_CMP:  st_q <= ST_RDST;
            default: st_q <= ST_WDST;
          endcase
        end
        ST_RDST: if (mem_ready) begin
          dst_q <= dst_nx;
          eq_q  <= lane_eq;
          st_q  <= ST_STEP;
        end
        ST_WDST: if (mem_ready) begin
          dst_q <= dst_nx;
          st_q  <= ST_STEP;
        end
        ST_STEP: begin
          if (rep_q == REP_NONE) begin
            done <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - CW'(1);
            if (finish) begin
              done <= 1'b1;
              st_q <= ST_IDLE;
            end else if (take_irq) begin
              done    <= 1'b1;
              intr    <= 1'b1;
              pc_back <= ovr_q ? 2'd2 : 2'd1;
              st_q    <= ST_IDLE;
            end else begin
              st_q <= ST_CHECK;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign zf      = eq_q;
  assign cnt_out = cnt_q;
  assign src_out = src_q;
  assign dst_out = dst_q;
  assign acc_out = acc_q;
endmodule

// File: rtl/strop_seq_chk.sv
module strop_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [1:0]    mem_seg,
  input logic          mem_ready,
  input logic          done,
  input logic          intr,
  input logic [1:0]    pc_back,
  input logic [AW-1:0] src_out,
  input logic [CW-1:0] cnt_out,
  input logic          busy,
  input logic          rep_none,
  input logic          ovr
);
  AST_WRITE_EXTRA: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_seg == 2'd1)); // R1

  AST_SRC_MOVES: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && mem_seg != 2'd1 && mem_ready) |=> (src_out != $past(src_out))); // R3

  AST_NORMAL_NO_BACKUP: assert property (@(posedge clk) disable iff (rst)
    (done && !intr) |-> (pc_back == 2'd0)); // R8

  AST_INTR_BACKUP: assert property (@(posedge clk) disable iff (rst)
    (done && intr) |-> (pc_back != 2'd0)); // R8

  AST_NOREP_COUNT: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && rep_none) |-> $stable(cnt_out)); // R10

  AST_OVR_SEG: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_seg == 2'd2) |-> (ovr && !mem_we)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5
endmodule

bind strop_seq strop_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg),
  .mem_ready(mem_ready), .done(done), .intr(intr), .pc_back(pc_back),
  .src_out(src_out), .cnt_out(cnt_out), .busy(busy_w), .rep_none(rep_none_w),
  .ovr(ovr_q));

// File: tb/strop_seq_bench.sv
module strop_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b0;
  logic [1:0]  rep = '0;
  logic        seg_ovr = 1'b0;
  logic        dir = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] cnt_in = '0, src_in = '0, dst_in = '0, acc_in = '0;
  logic        mem_req, mem_we, mem_wide, done, intr, zf;
  logic [1:0]  mem_seg, pc_back;
  logic [15:0] mem_addr, mem_wdata, cnt_out, src_out, dst_out, acc_out;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;

  logic [7:0] bm [0:2][0:255];
  int n_chk = 0, n_bad = 0, n_acc = 0;

  always #2 clk = ~clk;

  strop_seq u_strop_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .wide(wide), .rep(rep),
    .seg_ovr(seg_ovr), .dir(dir), .irq(irq), .cnt_in(cnt_in), .src_in(src_in),
    .dst_in(dst_in), .acc_in(acc_in), .mem_req(mem_req), .mem_we(mem_we),
    .mem_seg(mem_seg), .mem_addr(mem_addr), .mem_wide(mem_wide),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .done(done), .intr(intr), .pc_back(pc_back), .zf(zf), .cnt_out(cnt_out),
    .src_out(src_out), .dst_out(dst_out), .acc_out(acc_out));

  // Memory model: one access per two cycles, three segment spaces.
  always @(negedge clk) begin
    if (mem_req && !mem_ready) begin
      mem_ready <= 1'b1;
      n_acc = n_acc + 1;
      if (mem_we) begin
        bm[mem_seg][mem_addr[7:0]] = mem_wdata[7:0];
        if (mem_wide) bm[mem_seg][mem_addr[7:0] + 8'd1] = mem_wdata[15:8];
      end else begin
        mem_rdata <= {bm[mem_seg][mem_addr[7:0] + 8'd1], bm[mem_seg][mem_addr[7:0]]};
      end
    end else begin
      mem_ready <= 1'b0;
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic w, input logic [1:0] r,
                     input logic ov, input logic d, input logic [15:0] c,
                     input logic [15:0] s, input logic [15:0] t, input logic [15:0] a);
    int waited;
    @(negedge clk);
    op = o; wide = w; rep = r; seg_ovr = ov; dir = d;
    cnt_in = c; src_in = s; dst_in = t; acc_in = a;
    n_acc = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    if (!done) chk("R5 completion watchdog", 0, 1);
  endtask

  task automatic clear_mem();
    for (int g = 0; g < 3; g++)
      for (int i = 0; i < 256; i++) bm[g][i] = 8'h00;
  endtask

  task automatic t_reset();
    chk("R5 reset done", done, 0);
    chk("R5 reset mem_req", mem_req, 0);
    chk("R8 reset pc_back", pc_back, 0);
    chk("R8 reset intr", intr, 0);
  endtask

  task automatic t_move_byte_up();
    clear_mem();
    for (int i = 0; i < 4; i++) bm[0][8'h10 + i] = 8'hA0 + 8'(i);
    run(3'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'd4, 16'h0010, 16'h0040, 16'h0);
    for (int i = 0; i < 4; i++) chk("R1 move byte copied", bm[1][8'h40 + i], 8'hA0 + 8'(i));
    chk("R3 src incremented", src_out, 16'h0014);
    chk("R3 dst incremented", dst_out, 16'h0044);
    chk("R5 count exhausted", cnt_out, 0);
    chk("R1 accesses read+write per element", n_acc, 8);
  endtask

  task automatic t_move_word_down();
    clear_mem();
    bm[0][8'h30] = 8'h11; bm[0][8'h31] = 8'h22;
    bm[0][8'h2C] = 8'h55; bm[0][8'h2D] = 8'h66;
    run(3'd0, 1'b1, 2'd2, 1'b0, 1'b1, 16'd3, 16'h0030, 16'h0060, 16'h0);
    chk("R4 src word step down", src_out, 16'h002A);
    chk("R4 dst word step down", dst_out, 16'h005A);
    chk("R1 word low byte", bm[1][8'h60], 8'h11);
    chk("R1 word high byte", bm[1][8'h61], 8'h22);
    chk("R3 third word at lower address", {bm[1][8'h5D], bm[1][8'h5C]}, 16'h6655);
  endtask

  task automatic t_load_repeat();
    clear_mem();
    bm[0][8'h20] = 8'h11; bm[0][8'h21] = 8'h22; bm[0][8'h22] = 8'h33;
    run(3'd1, 1'b0, 2'd2, 1'b0, 1'b0, 16'd3, 16'h0020, 16'h0, 16'hBEEF);
    chk("R7 acc holds last byte", acc_out, 16'hBE33);
    chk("R6 load ignores repeat kind", cnt_out, 0);
    chk("R3 load src advance", src_out, 16'h0023);
  endtask

  task automatic t_store_repeat();
    clear_mem();
    run(3'd2, 1'b1, 2'd1, 1'b0, 1'b0, 16'd2, 16'h0, 16'h0080, 16'h1234);
    chk("R6 store word 0", {bm[1][8'h81], bm[1][8'h80]}, 16'h1234);
    chk("R6 store word 1", {bm[1][8'h83], bm[1][8'h82]}, 16'h1234);
    chk("R4 dst after two words", dst_out, 16'h0084);
    chk("R6 store runs to count", cnt_out, 0);
  endtask

  task automatic t_scan_while_equal();
    clear_mem();
    bm[1][8'h90] = 8'h41; bm[1][8'h91] = 8'h41; bm[1][8'h92] = 8'h42; bm[1][8'h93] = 8'h41;
    run(3'd3, 1'b0, 2'd1, 1'b0, 1'b0, 16'd10, 16'h0, 16'h0090, 16'hFF41);
    chk("R6 scan early stop count", cnt_out, 16'd7);
    chk("R2 scan dst", dst_out, 16'h0093);
    chk("R2 scan zf mismatch", zf, 0);
    chk("R2 scan accesses", n_acc, 3);
  endtask

  task automatic t_cmp_while_not_equal();
    clear_mem();
    bm[0][8'hA0] = 8'h01; bm[0][8'hA1] = 8'h02; bm[0][8'hA2] = 8'h03;
    bm[1][8'hA0] = 8'h09; bm[1][8'hA1] = 8'h09; bm[1][8'hA2] = 8'h03;
    run(3'd4, 1'b0, 2'd2, 1'b0, 1'b0, 16'd8, 16'h00A0, 16'h00A0, 16'h0);
    chk("R6 compare stop on equal count", cnt_out, 16'd5);
    chk("R2 compare src", src_out, 16'h00A3);
    chk("R2 compare zf equal", zf, 1);
  endtask

  task automatic t_zero_count();
    clear_mem();
    run(3'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'd0, 16'h0010, 16'h0020, 16'h0);
    chk("R9 no access", n_acc, 0);
    chk("R9 src unchanged", src_out, 16'h0010);
    chk("R9 count still zero", cnt_out, 0);
  endtask

  task automatic t_single_with_irq();
    clear_mem();
    irq = 1'b1;
    run(3'd2, 1'b0, 2'd0, 1'b0, 1'b0, 16'd5, 16'h0, 16'h00B0, 16'h0077);
    irq = 1'b0;
    chk("R10 one store", bm[1][8'hB0], 8'h77);
    chk("R10 count untouched", cnt_out, 16'd5);
    chk("R10 one access", n_acc, 1);
    chk("R10 irq ignored intr", intr, 0);
    chk("R10 irq ignored pc_back", pc_back, 0);
  endtask

  task automatic t_interrupt();
    clear_mem();
    bm[2][8'h10] = 8'h3C;
    irq = 1'b1;
    run(3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 16'd5, 16'h0010, 16'h0050, 16'h0);
    chk("R8 intr set", intr, 1);
    chk("R8 backup with override", pc_back, 2);
    chk("R8 one element done", cnt_out, 16'd4);
    chk("R8 src updated", src_out, 16'h0011);
    chk("R8 element written", bm[1][8'h50], 8'h3C);
    run(3'd0, 1'b0, 2'd1, 1'b0, 1'b0, 16'd5, 16'h0010, 16'h0050, 16'h0);
    irq = 1'b0;
    chk("R8 backup without override", pc_back, 1);
    chk("R8 accesses before stop", n_acc, 2);
  endtask

  task automatic t_override();
    clear_mem();
    bm[2][8'hC0] = 8'h5A; bm[2][8'hC1] = 8'h5B;
    bm[0][8'hC0] = 8'hEE; bm[0][8'hC1] = 8'hEE;
    run(3'd0, 1'b0, 2'd1, 1'b1, 1'b0, 16'd2, 16'h00C0, 16'h00D0, 16'h0);
    chk("R11 source from override", bm[1][8'hD0], 8'h5A);
    chk("R11 second from override", bm[1][8'hD1], 8'h5B);
    chk("R11 override space not written", bm[2][8'hD0], 8'h00);
  endtask

  task automatic t_finish_beats_irq();
    clear_mem();
    bm[1][8'hE0] = 8'h41;
    irq = 1'b1;
    run(3'd3, 1'b0, 2'd1, 1'b1, 1'b0, 16'd1, 16'h0, 16'h00E0, 16'h0041);
    chk("R12 no intr at last element", intr, 0);
    chk("R12 no backup at last element", pc_back, 0);
    chk("R12 count zero", cnt_out, 0);
    bm[1][8'hE8] = 8'h42;
    run(3'd3, 1'b0, 2'd1, 1'b0, 1'b0, 16'd6, 16'h0, 16'h00E8, 16'h0041);
    irq = 1'b0;
    chk("R12 early stop beats irq", intr, 0);
    chk("R12 early stop count", cnt_out, 16'd5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_move_byte_up();
    t_move_word_down();
    t_load_repeat();
    t_store_repeat();
    t_scan_while_equal();
    t_cmp_while_not_equal();
    t_zero_count();
    t_single_with_irq();
    t_interrupt();
    t_override();
    t_finish_beats_irq();
    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule